// File: doc/BRIEF.md
# Palette Attribute Controller

The block is the last stage before the color outputs of a planar display. Each clock it takes one pixel, given as a 4-bit foreground index, a 4-bit background index and a glyph bit, plus blank and border flags. It resolves the pixel to a 4-bit color index and applies the text-mode blink rule. It masks the index with the color plane enables and looks the result up in a sixteen-entry table of 6-bit colors. During border time it outputs the border color, and during blanking it outputs black.

Software reaches every register through one byte-wide write port. An internal phase flip-flop decides what each write means: the first write selects a register and the next write stores data into it. A read strobe of the separate status port puts the flip-flop back into the register-select phase, so software always has a known starting point. The select byte also carries a display-enable bit. While that bit is clear, the palette table is writable and the screen shows black. While it is set, the palette is shown and palette writes have no effect. The mode bits and the panning shift count are held and driven out to the neighbouring fetch and glyph stages.

Top module: `pal_attr_ctrl`

## Requirements
- R1: After reset, rgb_out is 0, all cfg outputs are 0, the display is disabled, every palette entry and the border color are 0, all four planes are enabled, and the port is in the register-select phase.
- R2: A status_rd strobe puts the port into the register-select phase. If bus_wr is high in the same cycle, that write is dropped.
- R3: In the register-select phase, a write takes the register number from bits 4:0 and the display-enable bit from bit 5, then moves the port to the data phase. The next write stores its data into the selected register and returns the port to the register-select phase.
- R4: While the last select byte had bit 5 = 0, rgb_out is 0 whatever the pixel inputs are.
- R5: Registers 0x00-0x0F (palette) store data only while the display-enable bit is 0. Registers 0x10-0x13 store data whatever the value of that bit.
- R6: A palette entry stores data bits 5:0 (bits 2:0 high-weight blue/green/red in the order red=0, green=1, blue=2; bits 5:3 low-weight in the same order). rgb_out shows the entry that the masked pixel index selects.
- R7: Register 0x12 bits 3:0 enable color planes 0-3. A disabled plane forces its bit of the index to 0 before the lookup.
- R8: When pix_border is high, rgb_out is register 0x11 bits 5:0. When pix_blank is high, rgb_out is 0. Blank takes priority over border.
- R9: Register 0x10 bit 0 = 1 (graphics) uses fg_idx directly and ignores pix_on and bg_idx. Bit 0 = 0 (text) uses fg_idx when pix_on = 1 and bg_idx otherwise.
- R10: In text mode with register 0x10 bit 3 = 1 (blink), bit 3 of bg_idx is treated as 0 when bg_idx is used. If bg_idx bit 3 is 1 and blink_phase is 0, the pixel shows the background even when pix_on = 1.
- R11: cfg_gfx, cfg_mono, cfg_dot9 and cfg_blink follow register 0x10 bits 0-3. cfg_pan follows register 0x13 bits 3:0. Register numbers 0x14-0x1F store nothing but still use up a data-phase write.
- R12: rgb_out shows, one clock after a rising edge, the result of the pixel inputs sampled at that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe of the shared select/data port |
| bus_wdata | input | 8 | Write byte |
| status_rd | input | 1 | Read strobe of the status port; clears the port phase |
| fg_idx | input | 4 | Foreground color index of the pixel |
| bg_idx | input | 4 | Background color index; bit 3 is the blink attribute in text mode |
| pix_on | input | 1 | Glyph bit: 1 selects foreground in text mode |
| pix_blank | input | 1 | Blanking interval, output black |
| pix_border | input | 1 | Overscan interval, output border color |
| blink_phase | input | 1 | Blink clock, 0 = off phase |
| rgb_out | output | 6 | Registered 6-bit color |
| cfg_gfx | output | 1 | Graphics mode bit |
| cfg_mono | output | 1 | Monochrome attribute bit |
| cfg_dot9 | output | 1 | Line-graphics 9th-dot replication bit |
| cfg_blink | output | 1 | Blink enable bit |
| cfg_pan | output | 4 | Horizontal pixel panning shift |

## Verification
A port phase that has slipped by one write is the hardest fault to see. The symptom is that register numbers land in data registers and the reverse. It becomes visible only at the next pixel lookup or cfg readout that depends on the damaged register, so the bench checks a pixel or a cfg output after each programming burst. A wrong display-enable latch or palette write gate shows on rgb_out one clock after the next pixel. The plane mask and the blink selection are each tested with index patterns where the wrong choice gives a different table entry.

// File: rtl/pal_pkg.sv
package pal_pkg;

   localparam int REG_SEL_W = 5;

   localparam logic [REG_SEL_W-1:0] SEL_MODE   = 5'h10;
   localparam logic [REG_SEL_W-1:0] SEL_BORDER = 5'h11;
   localparam logic [REG_SEL_W-1:0] SEL_PLANES = 5'h12;
   localparam logic [REG_SEL_W-1:0] SEL_PAN    = 5'h13;

   // field order matches the mode register bits 3..0
   typedef struct packed {
      logic blink_en;
      logic dot9;
      logic mono;
      logic gfx;
   } mode_t;

   typedef enum logic {
      PH_SELECT = 1'b0,
      PH_DATA   = 1'b1
   } port_phase_e;

endpackage

// File: rtl/pal_port_ctrl.sv
module pal_port_ctrl
   import pal_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 bus_wr,
   input  logic [DATA_W-1:0]    bus_wdata,
   input  logic                 status_rd,
   output port_phase_e          phase,
   output logic                 disp_en,
   output logic                 wr_en,
   output logic [REG_SEL_W-1:0] wr_sel,
   output logic [DATA_W-1:0]    wr_data
);

   localparam int EN_BIT = REG_SEL_W;

   if (DATA_W < EN_BIT + 1) begin : g_bad_width
      $error("pal_port_ctrl: DATA_W too small for select byte");
   end

   port_phase_e           phase_q;
   logic [REG_SEL_W-1:0]  sel_q;
   logic                  disp_q;
   logic                  unused_sel_hi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase_q <= PH_SELECT;
         sel_q   <= '0;
         disp_q  <= 1'b0;
      end else if (status_rd) begin
         phase_q <= PH_SELECT;
      end else if (bus_wr) begin
         if (phase_q == PH_SELECT) begin
            sel_q   <= bus_wdata[REG_SEL_W-1:0];
            disp_q  <= bus_wdata[EN_BIT];
            phase_q <= PH_DATA;
         end else begin
            phase_q <= PH_SELECT;
         end
      end
   end

   assign unused_sel_hi = ^bus_wdata;
   assign phase   = phase_q;
   assign disp_en = disp_q;
   assign wr_sel  = sel_q;
   assign wr_data = bus_wdata;
   assign wr_en   = bus_wr && !status_rd && (phase_q == PH_DATA);

endmodule

// File: rtl/pal_regfile.sv
module pal_regfile
   import pal_pkg::*;
#(
   parameter int IDX_W   = 4,
   parameter int COLOR_W = 6,
   parameter int PAN_W   = 4,
   parameter int DATA_W  = 8
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic                            wr_en,
   input  logic [REG_SEL_W-1:0]            wr_sel,
   input  logic [DATA_W-1:0]               wr_data,
   input  logic                            disp_en,
   output logic [(2**IDX_W)*COLOR_W-1:0]   pal_flat,
   output logic [COLOR_W-1:0]              border,
   output logic [IDX_W-1:0]                plane_en,
   output mode_t                           mode,
   output logic [PAN_W-1:0]                pan
);

   localparam int NUM_ENTRIES = 2**IDX_W;

   if (IDX_W > 4 || IDX_W < 1) begin : g_bad_idx
      $error("pal_regfile: palette must fit below register 0x10");
   end
   if (COLOR_W > DATA_W || PAN_W > DATA_W || IDX_W > DATA_W || DATA_W < 4) begin : g_bad_data
      $error("pal_regfile: field wider than data byte");
   end

   logic pal_wr;
   logic unused_data;

   assign pal_wr      = wr_en && !disp_en;
   assign unused_data = ^wr_data;

   for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
      logic [COLOR_W-1:0] entry_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            entry_q <= '0;
         else if (pal_wr && wr_sel == REG_SEL_W'(g))
            entry_q <= wr_data[COLOR_W-1:0];
      end
      assign pal_flat[g*COLOR_W +: COLOR_W] = entry_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         border   <= '0;
         plane_en <= '1;
         mode     <= '0;
         pan      <= '0;
      end else if (wr_en) begin
         unique case (wr_sel)
            SEL_MODE:   mode     <= mode_t'(wr_data[3:0]);
            SEL_BORDER: border   <= wr_data[COLOR_W-1:0];
            SEL_PLANES: plane_en <= wr_data[IDX_W-1:0];
            SEL_PAN:    pan      <= wr_data[PAN_W-1:0];
            default:    ;
         endcase
      end
   end

endmodule

// File: rtl/pal_pixel_path.sv
module pal_pixel_path #(
   parameter int IDX_W   = 4,
   parameter int COLOR_W = 6,
   parameter bit OUT_REG = 1'b1
) (
   input  logic                            clk,
   input  logic                            rst_n,
   input  logic [IDX_W-1:0]                fg_idx,
   input  logic [IDX_W-1:0]                bg_idx,
   input  logic                            pix_on,
   input  logic                            pix_blank,
   input  logic                            pix_border,
   input  logic                            blink_phase,
   input  logic                            disp_en,
   input  logic                            gfx,
   input  logic                            blink_en,
   input  logic [IDX_W-1:0]                plane_en,
   input  logic [(2**IDX_W)*COLOR_W-1:0]   pal_flat,
   input  logic [COLOR_W-1:0]              border,
   output logic [COLOR_W-1:0]              rgb
);

   localparam int TOP = IDX_W - 1;

   logic [IDX_W-1:0]   bg_eff;
   logic [IDX_W-1:0]   sel_idx;
   logic [IDX_W-1:0]   masked;
   logic [COLOR_W-1:0] looked;
   logic [COLOR_W-1:0] rgb_nxt;
   logic               blink_off;

   always_comb begin
      bg_eff = bg_idx;
      if (blink_en)
         bg_eff[TOP] = 1'b0;
   end

   assign blink_off = blink_en && bg_idx[TOP] && !blink_phase;

   always_comb begin
      if (gfx)
         sel_idx = fg_idx;
      else if (blink_off)
         sel_idx = bg_eff;
      else if (pix_on)
         sel_idx = fg_idx;
      else
         sel_idx = bg_eff;
   end

   assign masked = sel_idx & plane_en;
   assign looked = pal_flat[int'(masked)*COLOR_W +: COLOR_W];

   always_comb begin
      if (!disp_en || pix_blank)
         rgb_nxt = '0;
      else if (pix_border)
         rgb_nxt = border;
      else
         rgb_nxt = looked;
   end

   if (OUT_REG) begin : g_out_reg
      logic [COLOR_W-1:0] rgb_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            rgb_q <= '0;
         else
            rgb_q <= rgb_nxt;
      end
      assign rgb = rgb_q;
   end else begin : g_out_comb
      logic unused_clk;
      assign unused_clk = clk ^ rst_n;
      assign rgb = rgb_nxt;
   end

endmodule

// File: rtl/pal_attr_ctrl.sv
module pal_attr_ctrl
   import pal_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int IDX_W   = 4,
   parameter int COLOR_W = 6,
   parameter int PAN_W   = 4,
   parameter bit OUT_REG = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               bus_wr,
   input  logic [DATA_W-1:0]  bus_wdata,
   input  logic               status_rd,
   input  logic [IDX_W-1:0]   fg_idx,
   input  logic [IDX_W-1:0]   bg_idx,
   input  logic               pix_on,
   input  logic               pix_blank,
   input  logic               pix_border,
   input  logic               blink_phase,
   output logic [COLOR_W-1:0] rgb_out,
   output logic               cfg_gfx,
   output logic               cfg_mono,
   output logic               cfg_dot9,
   output logic               cfg_blink,
   output logic [PAN_W-1:0]   cfg_pan
);

   localparam int PAL_BITS = (2**IDX_W) * COLOR_W;

   port_phase_e           port_phase;
   logic                  disp_en;
   logic                  wr_en;
   logic [REG_SEL_W-1:0]  wr_sel;
   logic [DATA_W-1:0]     wr_data;
   logic [PAL_BITS-1:0]   pal_flat;
   logic [COLOR_W-1:0]    border;
   logic [IDX_W-1:0]      plane_en;
   mode_t                 mode;

   pal_port_ctrl #(.DATA_W(DATA_W)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .status_rd (status_rd),
      .phase     (port_phase),
      .disp_en   (disp_en),
      .wr_en     (wr_en),
      .wr_sel    (wr_sel),
      .wr_data   (wr_data)
   );

   pal_regfile #(
      .IDX_W(IDX_W), .COLOR_W(COLOR_W), .PAN_W(PAN_W), .DATA_W(DATA_W)
   ) u_regs (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (wr_en),
      .wr_sel   (wr_sel),
      .wr_data  (wr_data),
      .disp_en  (disp_en),
      .pal_flat (pal_flat),
      .border   (border),
      .plane_en (plane_en),
      .mode     (mode),
      .pan      (cfg_pan)
   );

   pal_pixel_path #(
      .IDX_W(IDX_W), .COLOR_W(COLOR_W), .OUT_REG(OUT_REG)
   ) u_pix (
      .clk         (clk),
      .rst_n       (rst_n),
      .fg_idx      (fg_idx),
      .bg_idx      (bg_idx),
      .pix_on      (pix_on),
      .pix_blank   (pix_blank),
      .pix_border  (pix_border),
      .blink_phase (blink_phase),
      .disp_en     (disp_en),
      .gfx         (mode.gfx),
      .blink_en    (mode.blink_en),
      .plane_en    (plane_en),
      .pal_flat    (pal_flat),
      .border      (border),
      .rgb         (rgb_out)
   );

   assign cfg_gfx   = mode.gfx;
   assign cfg_mono  = mode.mono;
   assign cfg_dot9  = mode.dot9;
   assign cfg_blink = mode.blink_en;

endmodule

// File: rtl/pal_attr_ctrl_chk.sv
module pal_attr_ctrl_chk #(
   parameter int DATA_W   = 8,
   parameter int COLOR_W  = 6,
   parameter int PAN_W    = 4,
   parameter int PAL_BITS = 96,
   parameter bit OUT_REG  = 1'b1
) (
   input logic                clk,
   input logic                rst_n,
   input logic                bus_wr,
   input logic [DATA_W-1:0]   bus_wdata,
   input logic                status_rd,
   input logic                pix_blank,
   input logic [COLOR_W-1:0]  rgb_out,
   input logic [PAN_W-1:0]    cfg_pan,
   input logic                port_phase,
   input logic                disp_en,
   input logic [PAL_BITS-1:0] pal_flat
);

   // R2
   status_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      status_rd |=> !port_phase);

   // R3
   phase_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !status_rd) |=> (port_phase != $past(port_phase)));

   // R5
   pal_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && !status_rd && port_phase && disp_en) |=> $stable(pal_flat));

   // R11
   pan_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!bus_wr || status_rd || !port_phase) |=> $stable(cfg_pan));

   if (OUT_REG) begin : g_reg_chk
      // R4
      disp_off_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
         !disp_en |=> (rgb_out == '0));
      // R8
      blank_black_chk: assert property (@(posedge clk) disable iff (!rst_n)
         pix_blank |=> (rgb_out == '0));
   end

   logic unused_chk;
   assign unused_chk = ^bus_wdata;

endmodule

bind pal_attr_ctrl pal_attr_ctrl_chk #(
   .DATA_W(DATA_W), .COLOR_W(COLOR_W), .PAN_W(PAN_W),
   .PAL_BITS((2**IDX_W)*COLOR_W), .OUT_REG(OUT_REG)
) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .bus_wr     (bus_wr),
   .bus_wdata  (bus_wdata),
   .status_rd  (status_rd),
   .pix_blank  (pix_blank),
   .rgb_out    (rgb_out),
   .cfg_pan    (cfg_pan),
   .port_phase (port_phase),
   .disp_en    (disp_en),
   .pal_flat   (pal_flat)
);

// File: tb/pal_attr_ctrl_test.sv
`timescale 1ns/1ps
module pal_attr_ctrl_test;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic       status_rd = 1'b0;
   logic [3:0] fg_idx = '0;
   logic [3:0] bg_idx = '0;
   logic       pix_on = 1'b0;
   logic       pix_blank = 1'b0;
   logic       pix_border = 1'b0;
   logic       blink_phase = 1'b1;
   logic [5:0] rgb_out;
   logic       cfg_gfx, cfg_mono, cfg_dot9, cfg_blink;
   logic [3:0] cfg_pan;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model of the programmed state
   bit         m_phase;
   logic [4:0] m_sel;
   bit         m_disp;
   logic [5:0] m_pal [16];
   logic [5:0] m_border;
   logic [3:0] m_planes;
   logic [3:0] m_mode;
   logic [3:0] m_pan;

   always #2.5 clk = ~clk;

   pal_attr_ctrl uut (
      .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
      .status_rd(status_rd), .fg_idx(fg_idx), .bg_idx(bg_idx), .pix_on(pix_on),
      .pix_blank(pix_blank), .pix_border(pix_border), .blink_phase(blink_phase),
      .rgb_out(rgb_out), .cfg_gfx(cfg_gfx), .cfg_mono(cfg_mono),
      .cfg_dot9(cfg_dot9), .cfg_blink(cfg_blink), .cfg_pan(cfg_pan)
   );

   task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   function automatic logic [5:0] exp_rgb(input logic [3:0] fg, input logic [3:0] bg,
                                          input bit on, input bit blank, input bit bord,
                                          input bit ph);
      logic [3:0] bgx;
      logic [3:0] idx;
      bgx = bg;
      if (m_mode[3]) bgx[3] = 1'b0;
      if (m_mode[0]) idx = fg;
      else if (m_mode[3] && bg[3] && !ph) idx = bgx;
      else idx = on ? fg : bgx;
      idx = idx & m_planes;
      if (!m_disp || blank) return 6'h00;
      if (bord) return m_border;
      return m_pal[idx];
   endfunction

   task automatic port_wr(input logic [7:0] d);
      @(negedge clk);
      bus_wr = 1'b1;
      bus_wdata = d;
      if (!m_phase) begin
         m_sel = d[4:0];
         m_disp = d[5];
         m_phase = 1'b1;
      end else begin
         m_phase = 1'b0;
         if (m_sel < 5'h10) begin
            if (!m_disp) m_pal[m_sel[3:0]] = d[5:0];
         end else if (m_sel == 5'h10) m_mode = d[3:0];
         else if (m_sel == 5'h11) m_border = d[5:0];
         else if (m_sel == 5'h12) m_planes = d[3:0];
         else if (m_sel == 5'h13) m_pan = d[3:0];
      end
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic status_read();
      @(negedge clk);
      status_rd = 1'b1;
      m_phase = 1'b0;
      @(negedge clk);
      status_rd = 1'b0;
   endtask

   task automatic set_reg(input logic [4:0] sel, input bit en, input logic [7:0] d);
      port_wr({2'b00, en, sel});
      port_wr(d);
   endtask

   task automatic pix(input string tag, input logic [3:0] fg, input logic [3:0] bg,
                      input bit on, input bit blank, input bit bord, input bit ph);
      @(negedge clk);
      fg_idx = fg; bg_idx = bg; pix_on = on;
      pix_blank = blank; pix_border = bord; blink_phase = ph;
      @(negedge clk);
      check(tag, {2'b00, rgb_out}, {2'b00, exp_rgb(fg, bg, on, blank, bord, ph)});
   endtask

   task automatic check_cfg(input string tag);
      check(tag, {cfg_blink, cfg_dot9, cfg_mono, cfg_gfx, cfg_pan}, {m_mode, m_pan});
   endtask

   initial begin
      #1_000_000;
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      int unused_seed;
      unused_seed = $urandom(32'h5EED);
      m_phase = 0; m_sel = '0; m_disp = 0; m_border = '0; m_planes = 4'hF;
      m_mode = '0; m_pan = '0;
      for (int i = 0; i < 16; i++) m_pal[i] = '0;

      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      check("R1 rgb", {2'b00, rgb_out}, 8'h00);
      check_cfg("R1 cfg");

      // R3 / R6 basic programming and lookup
      set_reg(5'h03, 0, 8'hEA);          // bits 7:6 dropped -> 0x2A
      set_reg(5'h05, 0, 8'h11);
      set_reg(5'h10, 0, 8'h01);          // graphics
      set_reg(5'h11, 1, 8'h15);          // border, display on
      pix("R6 lookup entry 3", 4'h3, 4'h0, 0, 0, 0, 1);
      pix("R6 lookup entry 5", 4'h5, 4'h0, 0, 0, 0, 1);

      // R12 latency: output changes only after the edge
      @(negedge clk);
      fg_idx = 4'h3;
      #1 check("R12 before edge", {2'b00, rgb_out}, {2'b00, m_pal[5]});
      @(negedge clk);
      check("R12 after edge", {2'b00, rgb_out}, {2'b00, m_pal[3]});

      // R5 palette write ignored while display on
      set_reg(5'h05, 1, 8'h3F);
      pix("R5 locked palette", 4'h5, 4'h0, 0, 0, 0, 1);
      set_reg(5'h13, 1, 8'h09);
      check_cfg("R5 pan writable with display on");

      // R2 status read restores select phase
      port_wr(8'h00);
      status_read();
      port_wr(8'h06);
      port_wr(8'h33);
      port_wr(8'h20);
      pix("R2 resync", 4'h6, 4'h0, 0, 0, 0, 1);

      // R2 write dropped when colliding with status read
      port_wr(8'h06);
      @(negedge clk);
      status_rd = 1'b1; bus_wr = 1'b1; bus_wdata = 8'h01;
      m_phase = 1'b0;
      @(negedge clk);
      status_rd = 1'b0; bus_wr = 1'b0;
      port_wr(8'h20);
      pix("R2 collision", 4'h6, 4'h0, 0, 0, 0, 1);

      // R4 display disabled
      port_wr(8'h03);
      status_read();
      pix("R4 display off", 4'h3, 4'h0, 0, 0, 0, 1);
      pix("R4 display off border", 4'h3, 4'h0, 0, 0, 1, 1);

      // R7 plane mask
      set_reg(5'h0F, 0, 8'h2C);
      set_reg(5'h12, 1, 8'h05);
      pix("R7 planes 0101", 4'hF, 4'h0, 0, 0, 0, 1);
      set_reg(5'h12, 1, 8'h0F);
      pix("R7 all planes", 4'hF, 4'h0, 0, 0, 0, 1);

      // R8 border and blank
      pix("R8 border", 4'h3, 4'h0, 0, 0, 1, 1);
      pix("R8 blank over border", 4'h3, 4'h0, 0, 1, 1, 1);

      // R9 text mode selection
      set_reg(5'h10, 1, 8'h00);
      pix("R9 text fg", 4'h3, 4'h5, 1, 0, 0, 1);
      pix("R9 text bg", 4'h3, 4'h5, 0, 0, 0, 1);
      set_reg(5'h10, 1, 8'h01);
      pix("R9 graphics ignores on", 4'h3, 4'h5, 0, 0, 0, 1);

      // R10 blink
      set_reg(5'h0D, 0, 8'h07);
      set_reg(5'h10, 1, 8'h08);
      pix("R10 bg bit3 forced", 4'h3, 4'hD, 0, 0, 0, 1);
      pix("R10 blink off phase", 4'h3, 4'hD, 1, 0, 0, 0);
      pix("R10 blink on phase", 4'h3, 4'hD, 1, 0, 0, 1);
      set_reg(5'h10, 1, 8'h00);
      pix("R10 no blink uses bit3", 4'h3, 4'hD, 0, 0, 0, 0);

      // R11 cfg bits and unused registers
      set_reg(5'h10, 1, 8'h0E);
      set_reg(5'h13, 1, 8'h0F);
      check_cfg("R11 cfg");
      set_reg(5'h17, 1, 8'hFF);
      check_cfg("R11 unused reg");
      port_wr(8'h33);                    // select phase again after unused write
      port_wr(8'h02);
      check_cfg("R11 phase after unused");

      // random mix, R6 against model
      for (int i = 0; i < 600; i++) begin
         int r;
         r = int'($urandom_range(0, 9));
         if (r < 4) port_wr(8'($urandom));
         else if (r == 4) status_read();
         else pix("R6 random", 4'($urandom), 4'($urandom), 1'($urandom),
                  ($urandom_range(0, 7) == 0), ($urandom_range(0, 5) == 0), 1'($urandom));
         if (i % 50 == 0) check_cfg("R11 random cfg");
      end

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule